// File: doc/BRIEF.md
# 31-Input Majority Voter

This block looks at 31 independent one-bit votes and raises a single flag when at least half of them plus one, sixteen or more, are high. It is purely combinational. It settles in the same cycle the votes change, and it holds no state. The flag can feed a register in the caller's clock domain, or it can be used directly as a glitch-tolerant decision.

Internally the votes are counted by a staged tree of ripple adders, and that count is also driven out. At the bottom of the tree, eight full adders each reduce three votes to a 2-bit count. Above them, two 2-bit adders, one 3-bit adder per half, and a final 4-bit adder merge the partial counts. The spare carry-in of every multi-bit adder takes one of the remaining raw votes, so all 31 votes are used with no padding.

A threshold parameter sets the decision point. With the default of sixteen, the flag is simply the top bit of the 5-bit count. Any other threshold selects a magnitude compare instead.

Top module: `maj_vote31`

## Requirements
- R1: `vote_o` is 1 exactly when the number of 1 bits on `votes_i` is greater than or equal to THRESH (default 16), and is 0 otherwise.
- R2: `tally_o` is the unsigned binary count (0 to 31) of 1 bits on `votes_i`.
- R3: With `votes_i` all 0, `tally_o` is 0 and `vote_o` is 0.
- R4: With `votes_i` all 1, `tally_o` is 31 and `vote_o` is 1.
- R5: Any pattern with exactly 15 bits set gives `vote_o` = 0. Any pattern with exactly 16 bits set gives `vote_o` = 1. This holds wherever the set bits are placed.
- R6: Every input bit position, including those wired to adder carry-ins (bits 12, 13, 14, 27, 28, 29 and 30), adds exactly one to `tally_o` when set. Clearing any one bit of an all-ones pattern gives 30.
- R7: The outputs depend only on the present value of `votes_i`, with no latency. A new input value is reflected in the same cycle.
- R8: With THRESH equal to 16, `vote_o` equals bit 4 of `tally_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| votes_i | input | 31 | One vote per bit, 1 = in favour |
| tally_o | output | 5 | Number of votes in favour |
| vote_o | output | 1 | High when the tally reaches THRESH |

## Verification
The hardest cases to reach are those that exercise the carry-in votes and the deepest carry ripple. Bits 12 to 14 and 27 to 30 enter the tree high up rather than at a full adder, and a wrong bit in one of those paths only shows for certain placements of the other set bits. The stimulus therefore walks a single one and a single zero across every position. It then builds many vectors with exactly k bits set, for every k from 0 to 31, by scattering the ones at random positions. Many of these vectors land on 15 and 16 set bits, so the threshold boundary is crossed with the ones spread differently over the two halves and the final carry-in.

// File: rtl/maj_pkg.sv
package maj_pkg;
   // Shape of the fixed adder tree
   localparam int unsigned TREE_IN    = 31;
   localparam int unsigned HALF_IN    = 15;
   localparam int unsigned HALF_SUM_W = 4;
   localparam int unsigned FA_PER_HALF = 4;
   localparam int unsigned L2_PER_HALF = 2;

   function automatic bit is_pow2(input int unsigned v);
      return (v != 0) && ((v & (v - 1)) == 0);
   endfunction
endpackage

// File: rtl/maj_fa.sv
module maj_fa (
   input  logic a_i,
   input  logic b_i,
   input  logic c_i,
   output logic s_o,
   output logic c_o
);
   logic ab_x;
   assign ab_x = a_i ^ b_i;
   assign s_o  = ab_x ^ c_i;
   assign c_o  = (a_i & b_i) | (c_i & ab_x);
endmodule

// File: rtl/maj_ripple.sv
module maj_ripple #(
   parameter int unsigned W = 2
) (
   input  logic [W-1:0] a_i,
   input  logic [W-1:0] b_i,
   input  logic         cin_i,
   output logic [W:0]   sum_o
);
   if (W < 1) begin : g_bad_w
      $error("maj_ripple: W must be at least 1");
   end

   logic [W:0] carry;
   assign carry[0] = cin_i;

   for (genvar gi = 0; gi < W; gi++) begin : g_bit
      maj_fa u_fa (
         .a_i (a_i[gi]),
         .b_i (b_i[gi]),
         .c_i (carry[gi]),
         .s_o (sum_o[gi]),
         .c_o (carry[gi+1])
      );
   end
   assign sum_o[W] = carry[W];

   always_comb begin
      AST_RIPPLE_SUM: assert (sum_o == ({1'b0, a_i} + {1'b0, b_i} + (W+1)'(cin_i)))
         else $error("ripple sum mismatch"); // R2
   end
endmodule

// File: rtl/maj_half_tree.sv
module maj_half_tree
   import maj_pkg::*;
#(
   parameter int unsigned N  = HALF_IN,
   parameter int unsigned SW = HALF_SUM_W
) (
   input  logic [N-1:0]  x_i,
   output logic [SW-1:0] cnt_o
);
   localparam int unsigned L1_IN  = 3 * FA_PER_HALF;   // raw votes into full adders
   localparam int unsigned L2_CIN = L1_IN;             // first carry-in vote
   localparam int unsigned L3_CIN = L1_IN + L2_PER_HALF;

   if (N != HALF_IN || SW != HALF_SUM_W) begin : g_bad_shape
      $error("maj_half_tree: tree is built for 15 inputs and a 4-bit count");
   end

   logic [1:0] l1 [FA_PER_HALF];
   logic [2:0] l2 [L2_PER_HALF];

   // Level 1: three votes per full adder
   for (genvar gf = 0; gf < FA_PER_HALF; gf++) begin : g_l1
      maj_fa u_fa (
         .a_i (x_i[3*gf]),
         .b_i (x_i[3*gf+1]),
         .c_i (x_i[3*gf+2]),
         .s_o (l1[gf][0]),
         .c_o (l1[gf][1])
      );
   end

   // Level 2: pairs of 2-bit counts, carry-in takes a raw vote
   for (genvar gp = 0; gp < L2_PER_HALF; gp++) begin : g_l2
      maj_ripple #(.W(2)) u_add (
         .a_i   (l1[2*gp]),
         .b_i   (l1[2*gp+1]),
         .cin_i (x_i[L2_CIN+gp]),
         .sum_o (l2[gp])
      );
   end

   // Level 3: final 3-bit merge, carry-in takes the last vote of the half
   maj_ripple #(.W(3)) u_l3 (
      .a_i   (l2[0]),
      .b_i   (l2[1]),
      .cin_i (x_i[L3_CIN]),
      .sum_o (cnt_o)
   );

   always_comb begin
      AST_HALF_ZERO: assert (!(x_i == '0) || cnt_o == '0)
         else $error("half tree nonzero for no votes"); // R3
      AST_HALF_FULL: assert (!(&x_i) || cnt_o == SW'(N))
         else $error("half tree short for all votes"); // R4
   end
endmodule

// File: rtl/maj_thresh.sv
module maj_thresh
   import maj_pkg::*;
#(
   parameter int unsigned SW     = 5,
   parameter int unsigned THRESH = 16
) (
   input  logic [SW-1:0] cnt_i,
   output logic          hit_o
);
   localparam int unsigned TOP_WEIGHT = 1 << (SW - 1);

   if (THRESH == TOP_WEIGHT) begin : g_msb
      // Threshold equals the top bit's weight: no compare needed
      assign hit_o = cnt_i[SW-1];
   end else begin : g_cmp
      assign hit_o = (cnt_i >= SW'(THRESH));
   end
endmodule

// File: rtl/maj_vote31.sv
module maj_vote31
   import maj_pkg::*;
#(
   parameter int unsigned N_IN   = 31,
   parameter int unsigned THRESH = 16
) (
   input  logic [N_IN-1:0]          votes_i,
   output logic [$clog2(N_IN+1)-1:0] tally_o,
   output logic                     vote_o
);
   localparam int unsigned SUM_W  = $clog2(N_IN + 1);
   localparam int unsigned HALF   = (N_IN - 1) / 2;
   localparam int unsigned HSW    = SUM_W - 1;
   localparam int unsigned LAST   = N_IN - 1;

   if (N_IN != TREE_IN) begin : g_bad_n
      $error("maj_vote31: N_IN must be 31");
   end
   if (THRESH < 1 || THRESH > N_IN) begin : g_bad_thresh
      $error("maj_vote31: THRESH must be within 1..N_IN");
   end

   logic [HSW-1:0] lo_cnt, hi_cnt;

   maj_half_tree #(.N(HALF), .SW(HSW)) u_lo (
      .x_i   (votes_i[HALF-1:0]),
      .cnt_o (lo_cnt)
   );
   maj_half_tree #(.N(HALF), .SW(HSW)) u_hi (
      .x_i   (votes_i[2*HALF-1:HALF]),
      .cnt_o (hi_cnt)
   );

   // Halves merged; the carry-in absorbs the odd vote out
   maj_ripple #(.W(HSW)) u_top (
      .a_i   (lo_cnt),
      .b_i   (hi_cnt),
      .cin_i (votes_i[LAST]),
      .sum_o (tally_o)
   );

   maj_thresh #(.SW(SUM_W), .THRESH(THRESH)) u_cmp (
      .cnt_i (tally_o),
      .hit_o (vote_o)
   );

   always_comb begin
      AST_TALLY_POP: assert (32'(tally_o) == 32'($countones(votes_i)))
         else $error("tally differs from population count"); // R2
      AST_VOTE_THRESH: assert (vote_o == (32'(tally_o) >= THRESH))
         else $error("vote disagrees with tally"); // R1
      AST_ALL_ZERO: assert (!(votes_i == '0) || (tally_o == '0 && !vote_o))
         else $error("nonzero result for no votes"); // R3
      AST_ALL_ONE: assert (!(&votes_i) || (32'(tally_o) == N_IN && vote_o))
         else $error("short result for all votes"); // R4
      AST_MSB_FORM: assert (THRESH != 16 || vote_o == tally_o[SUM_W-1])
         else $error("vote is not the count top bit"); // R8
   end
endmodule

// File: tb/maj_vote31_test.sv
module maj_vote31_test;
   localparam int N = 31;
   localparam int TH = 16;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic [N-1:0]  votes = '0;
   logic [4:0]    tally;
   logic          vote;
   int            n_vec = 0;
   int            n_bad = 0;
   int            cycles = 0;
   bit            done = 1'b0;

   always #10 clk = ~clk;   // 50 MHz

   maj_vote31 #(.N_IN(N), .THRESH(TH)) uut (
      .votes_i (votes),
      .tally_o (tally),
      .vote_o  (vote)
   );

   function automatic int ref_count(input logic [N-1:0] v);
      int c = 0;
      for (int i = 0; i < N; i++) if (v[i]) c++;
      return c;
   endfunction

   task automatic summary();
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   endtask

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles > 150000 && !done) begin
         done = 1'b1;
         n_bad++;
         $display("FAIL watchdog: run hung, actual %0d cycles expected < 150000", cycles);
         summary();
      end
   end

   // Drive just after a rising edge, sample at the falling edge (same cycle: R7)
   task automatic apply(input logic [N-1:0] v, input string tag);
      int exp_n;
      @(posedge clk);
      #1 votes = v;
      @(negedge clk);
      exp_n = ref_count(v);
      n_vec++;
      if (int'(tally) != exp_n) begin
         n_bad++;
         $display("FAIL %s/R2/R7: tally for %h actual %0d expected %0d", tag, v, tally, exp_n);
      end
      if (vote != (exp_n >= TH)) begin
         n_bad++;
         $display("FAIL %s/R1: vote for %h actual %0b expected %0b", tag, v, vote, exp_n >= TH);
      end
      if (vote != tally[4]) begin
         n_bad++;
         $display("FAIL R8: vote %0b versus tally bit4 %0b", vote, tally[4]);
      end
   endtask

   function automatic logic [N-1:0] scatter(input int k);
      logic [N-1:0] v = '0;
      int set = 0;
      while (set < k) begin
         int p = int'($urandom % N);
         if (!v[p]) begin
            v[p] = 1'b1;
            set++;
         end
      end
      return v;
   endfunction

   initial begin
      repeat (3) @(posedge clk);
      rst = 1'b0;
      // Reset state: idle inputs give a zero result
      @(negedge clk);
      n_vec++;
      if (tally != 5'd0 || vote != 1'b0) begin
         n_bad++;
         $display("FAIL R3: idle outputs actual %0d/%0b expected 0/0", tally, vote);
      end
      apply('0, "R3");
      apply('1, "R4");
      for (int i = 0; i < N; i++) apply(N'(1) << i, "R6");
      for (int i = 0; i < N; i++) apply(~(N'(1) << i), "R6");
      // Boundary: 15 low half + 16 set, various placements
      apply(N'(32'h0000_7fff), "R5");
      apply(N'(32'h7fff_8000), "R5");
      apply(N'(32'h4000_7fff), "R5");
      apply(N'(32'h7000_0fff), "R5");
      for (int r = 0; r < 40; r++) begin
         apply(scatter(15), "R5");
         apply(scatter(16), "R5");
      end
      for (int k = 0; k <= N; k++)
         for (int r = 0; r < 4; r++) apply(scatter(k), "R1");
      for (int r = 0; r < 400; r++) apply(N'($urandom), "R2");
      // Back-to-back swings: each new value seen in its own cycle
      for (int r = 0; r < 20; r++) begin
         apply('0, "R7");
         apply('1, "R7");
      end
      done = 1'b1;
      summary();
   end
endmodule